// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

This block is a 64-bit integer add/subtract unit whose carry path can be cut into independent lanes. One operation can treat the operands as a single 64-bit word, as two 32-bit lanes, as four 16-bit lanes or as eight 8-bit lanes. Each lane can be signed or unsigned. Each lane either wraps modulo its width or clamps to the nearest representable extreme when the true result does not fit.

Subtraction inverts the second operand and injects a carry of one into the lowest bit of every lane. Overflow is never raised as a trap. It is reported as one flag per lane, whether or not clamping is enabled. The arithmetic is purely combinational. A parameter adds one output register stage, and that stage is enabled by default.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives one 64-bit lane. No carry crosses from one lane into the next. Lane k occupies result bits [k*w+w-1 : k*w].
- R2: When `sub_sel`=0 and saturation is off, each lane of `result` equals (a + b) mod 2^w, taken over that lane's bits.
- R3: When `sub_sel`=1, each lane computes a + ~b + 1, which is a - b mod 2^w. The +1 enters at the least significant bit of every lane.
- R4: For signed addition (`signed_sel`=1), the lane flag is set only when both operand lane sign bits are equal and the sign bit of the wrapped result differs from them. Operands of opposite sign never set the flag.
- R5: For signed subtraction, operands with equal sign bits never set the flag. Positive minus negative sets it when the result sign is 1. Negative minus positive sets it when the result sign is 0.
- R6: For unsigned addition, the lane flag is the carry out of the lane's top bit. With `sat_en`=1, a flagged lane outputs all ones.
- R7: For unsigned subtraction, the lane flag is set when there is no carry out of the lane's top bit, which means b > a. With `sat_en`=1, a flagged lane outputs zero.
- R8: For signed modes with `sat_en`=1, a flagged lane outputs 0111…1 when operand a is non-negative and 1000…0 when operand a is negative. Each lane clamps independently of the others.
- R9: `ovf[k]` is the flag of lane k. Bits of `ovf` at or above the lane count (8, 4, 2 or 1) are 0. Flags are reported the same way whether `sat_en` is 0 or 1.
- R10: With `sat_en`=0, a flagged lane still outputs its wrapped result.
- R11: With `OUT_REG`=1, `result` and `ovf` show the outcome of the inputs present at the previous rising clock edge. While `rst_n` is low, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (subtrahend when subtracting) |
| lane_mode | input | 2 | Lane width select: 0=8, 1=16, 2=32, 3=64 bits |
| sub_sel | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| signed_sel | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| result | output | 64 | Lane results |
| ovf | output | 8 | Per-lane overflow flags, lane k on bit k |

## Verification
The bench targets lane boundaries with operands that carry out of every lane, such as 0xFF + 0x01 in 8-bit mode. A design that leaked a carry across a boundary would show a stray 1 in the next lane. It also drives the signed extremes 0x7F + 1 and 0x80 - 1 and their 16-bit counterparts. A design that saturated in the wrong direction, or judged signed overflow from the carry out, would clamp to the wrong end or miss the flag. Unsigned borrow is checked too, because an inverted borrow sense would saturate 0 - 1 to all ones. Flags are checked in the wider modes, where reporting a lane's flag from a lower slice or leaving the unused flag bits set would show up. Wrap-mode vectors confirm that a flagged lane is not clamped.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2,
    LW64 = 2'd3
  } lane_w_e;

  // number of slices spanned by one lane for a given lane width code
  function automatic int slices_per_lane(input lane_w_e m);
    return 1 << int'(m);
  endfunction

endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_x;
  logic [W:0]   total;

  always_comb begin
    b_x    = b_i ^ {W{inv_i}};
    total  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, cin_i};
    sum_o  = total[W-1:0];
    cout_o = total[W];
  end
endmodule

// File: rtl/simd_carry_chain.sv
module simd_carry_chain
  import simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lane_w_e           mode_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NSLICE-1:0] cout_o
);
  logic [IDX_W-1:0] span_mask;
  logic             cin_s  [NSLICE];
  logic             cout_s [NSLICE];

  always_comb span_mask = IDX_W'(slices_per_lane(mode_i) - 1);

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);

    if (i == 0) begin : g_first
      assign cin_s[i] = sub_i;
    end else begin : g_rest
      // a slice at the base of a lane takes the subtract carry, never the neighbour's
      assign cin_s[i] = ((IDX & span_mask) == '0) ? sub_i : cout_s[i-1];
    end

    simd_slice_add #(.W(SLICE_W)) u_add (
      .a_i    (a_i[i*SLICE_W +: SLICE_W]),
      .b_i    (b_i[i*SLICE_W +: SLICE_W]),
      .inv_i  (sub_i),
      .cin_i  (cin_s[i]),
      .sum_o  (sum_o[i*SLICE_W +: SLICE_W]),
      .cout_o (cout_s[i])
    );

    assign cout_o[i] = cout_s[i];
  end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
  import simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NSLICE-1:0] cout_i,
  input  logic [NSLICE-1:0] a_msb_i,
  input  logic [NSLICE-1:0] b_msb_i,
  input  lane_w_e           mode_i,
  input  logic              sub_i,
  input  logic              sgn_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NSLICE-1:0] lane_ovf_o
);
  logic [IDX_W-1:0]  span_mask;
  logic [NSLICE-1:0] ovf_here;
  logic [NSLICE-1:0] low_here;

  always_comb span_mask = IDX_W'(slices_per_lane(mode_i) - 1);

  // overflow verdict as if each slice were the top of its lane
  for (genvar i = 0; i < NSLICE; i++) begin : g_judge
    logic r_msb, bx_msb, s_ovf, u_ovf;
    always_comb begin
      r_msb       = sum_i[i*SLICE_W + SLICE_W - 1];
      bx_msb      = b_msb_i[i] ^ sub_i;
      s_ovf       = (a_msb_i[i] == bx_msb) && (r_msb != a_msb_i[i]);
      u_ovf       = sub_i ? ~cout_i[i] : cout_i[i];
      ovf_here[i] = sgn_i ? s_ovf : u_ovf;
      low_here[i] = sgn_i ? a_msb_i[i] : sub_i;
    end
  end

  // every slice follows the verdict of its lane's top slice
  for (genvar i = 0; i < NSLICE; i++) begin : g_clamp
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic [IDX_W-1:0]   top;
    logic               is_top, low;
    logic [SLICE_W-1:0] clamp;
    always_comb begin
      top           = IDX | span_mask;
      is_top        = (top == IDX);
      lane_ovf_o[i] = ovf_here[top];
      low           = low_here[top];
      clamp         = low ? '0 : '1;
      clamp[SLICE_W-1] = clamp[SLICE_W-1] ^ (sgn_i & is_top);
      res_o[i*SLICE_W +: SLICE_W] = (sat_i && lane_ovf_o[i]) ? clamp
                                   : sum_i[i*SLICE_W +: SLICE_W];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_mode,
  input  logic              sub_sel,
  input  logic              signed_sel,
  input  logic              sat_en,
  output logic [DATA_W-1:0] result,
  output logic [NSLICE-1:0] ovf
);
  lane_w_e           mode;
  logic [DATA_W-1:0] sum_w;
  logic [NSLICE-1:0] cout_w;
  logic [NSLICE-1:0] a_msb, b_msb;
  logic [NSLICE-1:0] lane_ovf;
  logic [DATA_W-1:0] res_d;
  logic [NSLICE-1:0] ovf_d;

  always_comb mode = lane_w_e'(lane_mode);

  for (genvar i = 0; i < NSLICE; i++) begin : g_msb
    assign a_msb[i] = op_a[i*SLICE_W + SLICE_W - 1];
    assign b_msb[i] = op_b[i*SLICE_W + SLICE_W - 1];
  end

  simd_carry_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
    .a_i    (op_a),
    .b_i    (op_b),
    .mode_i (mode),
    .sub_i  (sub_sel),
    .sum_o  (sum_w),
    .cout_o (cout_w)
  );

  simd_lane_sat #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_sat (
    .sum_i      (sum_w),
    .cout_i     (cout_w),
    .a_msb_i    (a_msb),
    .b_msb_i    (b_msb),
    .mode_i     (mode),
    .sub_i      (sub_sel),
    .sgn_i      (signed_sel),
    .sat_i      (sat_en),
    .res_o      (res_d),
    .lane_ovf_o (lane_ovf)
  );

  // gather one flag per lane from the top slice of each lane
  for (genvar k = 0; k < NSLICE; k++) begin : g_flag
    int lanes, span;
    always_comb begin
      span  = slices_per_lane(mode);
      lanes = NSLICE / span;
      if (k < lanes) ovf_d[k] = lane_ovf[IDX_W'((k + 1) * span - 1)];
      else           ovf_d[k] = 1'b0;
    end
  end

  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] res_q, res_nxt;
    logic [NSLICE-1:0] ovf_q, ovf_nxt;

    always_comb begin
      res_nxt = res_d;
      ovf_nxt = ovf_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        ovf_q <= '0;
      end else begin
        res_q <= res_nxt;
        ovf_q <= ovf_nxt;
      end
    end

    assign result = res_q;
    assign ovf    = ovf_q;
  end else begin : g_comb
    assign result = res_d;
    assign ovf    = ovf_d;
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W  = 64,
  parameter int NSLICE  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        lane_mode,
  input logic              sub_sel,
  input logic              signed_sel,
  input logic              sat_en,
  input logic [DATA_W-1:0] res_d,
  input logic [NSLICE-1:0] ovf_d,
  input logic [DATA_W-1:0] result,
  input logic [NSLICE-1:0] ovf
);
  assert_lane_isolate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && !sub_sel && !sat_en) |-> (res_d[15:8] == 8'(op_a[15:8] + op_b[15:8])));

  assert_wrap64_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd3 && !sub_sel && !sat_en) |-> (res_d == op_a + op_b));

  assert_sub8_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && sub_sel && !sat_en) |-> (res_d[7:0] == 8'(op_a[7:0] - op_b[7:0])));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && signed_sel && !sub_sel && (op_a[7] != op_b[7])) |-> !ovf_d[0]);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && signed_sel && sub_sel && (op_a[7] == op_b[7])) |-> !ovf_d[0]);

  assert_usat_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && !signed_sel && !sub_sel && sat_en && ovf_d[0]) |-> (res_d[7:0] == 8'hFF));

  assert_usat_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && !signed_sel && sub_sel && sat_en && ovf_d[0]) |-> (res_d[7:0] == 8'h00));

  assert_ssat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && signed_sel && sat_en && ovf_d[0]) |-> (res_d[7:0] == (op_a[7] ? 8'h80 : 8'h7F)));

  assert_flag_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd3) |-> (ovf_d[NSLICE-1:1] == '0));

  assert_wrap_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd0 && !signed_sel && !sub_sel && !sat_en) |-> (res_d[7:0] == 8'(op_a[7:0] + op_b[7:0])));

  if (OUT_REG) begin : g_reg_chk
    assert_out_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (result == $past(res_d) && ovf == $past(ovf_d)));
  end else begin : g_comb_chk
    assert_comb_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (result == res_d && ovf == ovf_d));
  end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(
  .DATA_W (DATA_W),
  .NSLICE (NSLICE),
  .OUT_REG(OUT_REG)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .lane_mode  (lane_mode),
  .sub_sel    (sub_sel),
  .signed_sel (signed_sel),
  .sat_en     (sat_en),
  .res_d      (res_d),
  .ovf_d      (ovf_d),
  .result     (result),
  .ovf        (ovf)
);

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic [1:0]  lane_mode;
  logic        sub_sel, signed_sel, sat_en;
  logic [63:0] result;
  logic [7:0]  ovf;

  typedef struct {
    logic [63:0] res;
    logic [7:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  simd_sat_adder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .lane_mode  (lane_mode),
    .sub_sel    (sub_sel),
    .signed_sel (signed_sel),
    .sat_en     (sat_en),
    .result     (result),
    .ovf        (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // reference built from the requirements, lane by lane
  task automatic model(input logic [63:0] a, input logic [63:0] b, input int mode,
                       input bit sub, input bit sgn, input bit sat,
                       output logic [63:0] res, output logic [7:0] fl);
    int w, nl;
    logic [63:0] mask, av, bv, r, sv;
    logic [64:0] raw;
    bit carry, sa, sb, sr, o;
    w  = 8 << mode;
    nl = 8 >> mode;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    res = '0;
    fl  = '0;
    for (int k = 0; k < nl; k++) begin
      av  = (a >> (k * w)) & mask;
      bv  = (b >> (k * w)) & mask;
      raw = {1'b0, av} + {1'b0, (sub ? (~bv & mask) : bv)} + 65'(sub);
      carry = raw[w];
      r   = raw[63:0] & mask;
      sa  = av[w-1];
      sb  = bv[w-1];
      sr  = r[w-1];
      if (sgn) begin
        if (!sub) o = (sa == sb) && (sr != sa);
        else      o = (sa != sb) && (sr != sa);
        sv = sa ? (64'd1 << (w - 1)) : (mask >> 1);
      end else begin
        o  = sub ? !carry : carry;
        sv = sub ? 64'd0 : mask;
      end
      if (sat && o) r = sv;
      res |= r << (k * w);
      fl[k] = o;
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input int mode,
                       input bit sub, input bit sgn, input bit sat, input string tag);
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; lane_mode = 2'(mode);
    sub_sel = sub; signed_sel = sgn; sat_en = sat;
    model(a, b, mode, sub, sgn, sat, e.res, e.fl);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: one item leaves the queue per clock, after the output stage settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.res || ovf !== e.fl) begin
          errors++;
          $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                   e.tag, result, ovf, e.res, e.fl);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11: actual=hung expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1;
    lane_mode = 2'd0; sub_sel = 1'b0; signed_sel = 1'b0; sat_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;   // R11 reset state
    if (result !== '0 || ovf !== '0) begin
      errors++;
      $display("FAIL R11 reset: result=%h ovf=%b expected 0 0", result, ovf);
    end
    rst_n = 1'b1;

    drive(64'h0000_0000_0000_00FF, 64'h1, 0, 0, 0, 0, "R1 8-bit carry stays in lane");
    drive(64'h0000_0000_0000_00FF, 64'h1, 1, 0, 0, 0, "R1 16-bit carry crosses slice");
    drive(64'h0000_0000_FFFF_FFFF, 64'h1, 2, 0, 0, 0, "R1 32-bit lane boundary");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3, 0, 0, 0, "R2 64-bit wrap");
    drive(64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1, 0, 0, 0, "R2 16-bit add");
    drive(64'h0707_0707_0707_0707, 64'h0606_0606_0606_0606, 0, 1, 0, 0, "R3 per-lane +1");
    drive(64'h0, 64'h1, 3, 1, 0, 0, "R3 64-bit subtract");
    drive(64'h7F, 64'h01, 0, 0, 1, 1, "R4 pos+pos clamp");
    drive(64'h80, 64'hFF, 0, 0, 1, 1, "R4 neg+neg clamp");
    drive(64'h7F, 64'h80, 0, 0, 1, 1, "R4 opposite signs no flag");
    drive(64'h80, 64'h01, 0, 1, 1, 1, "R5 neg-pos clamp");
    drive(64'h7F, 64'hFF, 0, 1, 1, 1, "R5 pos-neg clamp");
    drive(64'h80, 64'h80, 0, 1, 1, 1, "R5 same sign no flag");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, 1, "R6 unsigned clamp all lanes");
    drive(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2, 1, 0, 1, "R7 unsigned borrow clamp");
    drive(64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_0000_0001, 1, 0, 1, 1, "R8 16-bit mixed clamp");
    drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3, 0, 1, 1, "R8 64-bit negative clamp");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3, 0, 0, 1, "R9 single flag in 64-bit mode");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2, 0, 0, 0, "R9 two flags without clamp");
    drive(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 0, 0, 1, 0, "R10 signed wrap kept");

    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (n % 5 == 0) b = ~a;
      drive(a, b, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            "R2 R3 R6 R7 R8 R9 random mix");
    end

    @(negedge clk);
    op_a = '0; op_b = '0;
    while (q.size() > 0) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule